// File: doc/BRIEF.md
# UART Interrupt Pending Controller

This block gathers the four interrupt causes of one serial port (receive, error, transmit and modem) into a sticky source register. It also holds a mask register. The unmasked part of the source register is shown as the pending vector, and any pending bit raises a single level-sensitive interrupt line. Software clears causes by writing ones, either through the pending view or straight into the source register. A write to the mask replaces the whole mask.

The transmit cause has two origins. A pulse marks each completed transmit write. A threshold comparator also sets the cause on every cycle in which the transmit FIFO is enabled and its fill count is at or below a trigger level. That level is a 3-bit code multiplied by a factor chosen by the `CHANNEL` parameter of the instance. The factor is 32 for channel 0, 8 for channels 1 and 4, and 2 for channels 2 and 3. Any other channel number gives a level of zero.

Bus decoding and the FIFOs stay outside the block. It receives decoded write strobes, a write-data nibble, the trigger code and the transmit fill count.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Source bit positions are fixed: bit 0 receive, bit 1 error, bit 2 transmit, bit 3 modem. A high `src_set[i]` at a clock edge makes `srcp_q[i]` 1 after that edge, and the bit stays set until it is cleared.
- R2: `pend` equals `srcp_q & ~mask_q` in the same cycle, with no register in between.
- R3: `irq` is high exactly when at least one bit of `pend` is 1.
- R4: A write with `pend_wr` high clears, at the next edge, every source bit whose `wr_data` bit is 1. The matching pending bits therefore drop too. Source bits whose `wr_data` bit is 0 are left unchanged.
- R5: A write with `srcp_wr` high clears, at the next edge, every source bit whose `wr_data` bit is 1. Other source bits are left unchanged.
- R6: A write with `mask_wr` high loads `wr_data` into `mask_q` at the next edge, and it leaves `srcp_q` unchanged.
- R7: While `fifo_en` is high and `tx_count` is at or below the trigger level, `srcp_q[2]` is set at each edge. While `fifo_en` is low, the threshold sets nothing.
- R8: The trigger level is `tx_trig_code` times a factor. The factor is 32 for channel 0, 8 for channels 1 and 4, and 2 for channels 2 and 3. Any other channel gives a level of 0, so only an empty FIFO matches.
- R9: A high `tx_write_done` at an edge sets `srcp_q[2]`.
- R10: If a bit is set and cleared in the same cycle, setting wins. This also covers a threshold match during a clear of the transmit bit.
- R11: While `rst_n` is low at an edge, `srcp_q` and `mask_q` become 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_set | input | 4 | One-cycle set pulses, one per source bit |
| tx_write_done | input | 1 | Pulse for each completed transmit write |
| fifo_en | input | 1 | FIFO enable; gates the threshold comparator |
| tx_trig_code | input | 3 | Transmit trigger code |
| tx_count | input | 8 | Transmit FIFO fill count |
| pend_wr | input | 1 | Write-one-to-clear strobe for the pending view |
| srcp_wr | input | 1 | Write-one-to-clear strobe for the source register |
| mask_wr | input | 1 | Load strobe for the mask register |
| wr_data | input | 4 | Write data for all three strobes |
| srcp_q | output | 4 | Source-pending register |
| mask_q | output | 4 | Mask register |
| pend | output | 4 | Masked pending vector |
| irq | output | 1 | Level interrupt line |

## Verification
The assertions check on every cycle that set pulses, threshold matches and transmit-done pulses land in the source register. They also check that clears without a concurrent set take effect, that set beats clear, that a mask write loads, and that the pending vector never shows a masked bit or a bit with no source behind it. Only the directed scenarios can show the exact trigger level for each channel factor. The same holds for the boundary at which a count one above the level stops matching, for a cleared bit staying clear when the FIFO is disabled, and for the register contents after reset.

// File: rtl/uirq_pkg.sv
// Package: shared constants for the UART interrupt pending controller.
// Assumes four interrupt sources with the fixed bit positions below.
package uirq_pkg;
    localparam int NUM_SRC   = 4;
    localparam int SRC_RX    = 0;
    localparam int SRC_ERR   = 1;
    localparam int SRC_TX    = 2;
    localparam int SRC_MODEM = 3;

    // Multiplier applied to the transmit trigger code for a given channel.
    function automatic int trig_factor(input int ch);
        case (ch)
            0:       return 32;
            1, 4:    return 8;
            2, 3:    return 2;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/uirq_tx_thresh.sv
// Module: transmit FIFO threshold comparator.
// Flags a match when the FIFO is enabled and the fill count is at or below
// code * factor. The factor comes from the CHANNEL parameter; an unsupported
// channel gives a level of zero. Purely combinational.
module uirq_tx_thresh #(
    parameter int CHANNEL = 0,
    parameter int CODE_W  = 3,
    parameter int CNT_W   = 8
) (
    input  logic              fifo_en,
    input  logic [CODE_W-1:0] code,
    input  logic [CNT_W-1:0]  count,
    output logic              tx_hit
);
    localparam int FACTOR = uirq_pkg::trig_factor(CHANNEL);
    localparam int LVL_W  = CODE_W + 6;
    localparam int CMP_W  = (LVL_W > CNT_W) ? LVL_W : CNT_W;

    logic [LVL_W-1:0] level;

    // Trigger level: pick the variant for this channel.
    generate
        if (FACTOR == 0) begin : g_no_level
            assign level = '0;
        end else begin : g_scaled_level
            assign level = LVL_W'(code) * LVL_W'(FACTOR);
        end
    endgenerate

    // Threshold comparison, gated by FIFO enable.
    assign tx_hit = fifo_en && (CMP_W'(count) <= CMP_W'(level));
endmodule

// File: rtl/uirq_src_reg.sv
// Module: sticky source-pending register.
// Each bit is set by set_vec and cleared by clr_vec. Set wins over clear in
// the same cycle. Assumes synchronous active-low reset.
module uirq_src_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] q
);
    // State update: clear first, then OR in the sets.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr_vec) | set_vec;
    end

    // R1: every requested set lands
    assert_set_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((q & $past(set_vec)) == $past(set_vec)));

    // R4/R5: a clear without a concurrent set empties the bit
    assert_clear_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~set_vec) != '0) |=> ((q & $past(clr_vec & ~set_vec)) == '0));

    // R10: set beats clear in the same cycle
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec & clr_vec) != '0) |=> ((q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));
endmodule

// File: rtl/uirq_pend_gen.sv
// Module: mask register and pending/interrupt generation.
// The mask loads whole on a write strobe. The pending vector and the line
// follow the source and mask state combinationally.
module uirq_pend_gen #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_wr,
    input  logic [N-1:0] wr_data,
    input  logic [N-1:0] srcp,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] pend,
    output logic         irq
);
    // Mask register load.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wr_data;
    end

    // Masked pending view and interrupt line.
    always_comb begin
        pend = srcp & ~mask_q;
        irq  = |pend;
    end

    // R6: a mask write loads the written value
    assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_q == $past(wr_data)));
endmodule

// File: rtl/uart_irq_ctrl.sv
// Module: UART interrupt pending controller (top).
// Combines receive/error/transmit/modem causes into the source register,
// applies the mask and drives a level interrupt. The transmit cause is also
// set by the FIFO threshold comparator. Assumes write strobes are already
// decoded and last one cycle each.
module uart_irq_ctrl #(
    parameter int CHANNEL = 0,
    parameter int CODE_W  = 3,
    parameter int CNT_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [uirq_pkg::NUM_SRC-1:0] src_set,
    input  logic                      tx_write_done,
    input  logic                      fifo_en,
    input  logic [CODE_W-1:0]         tx_trig_code,
    input  logic [CNT_W-1:0]          tx_count,
    input  logic                      pend_wr,
    input  logic                      srcp_wr,
    input  logic                      mask_wr,
    input  logic [uirq_pkg::NUM_SRC-1:0] wr_data,
    output logic [uirq_pkg::NUM_SRC-1:0] srcp_q,
    output logic [uirq_pkg::NUM_SRC-1:0] mask_q,
    output logic [uirq_pkg::NUM_SRC-1:0] pend,
    output logic                      irq
);
    import uirq_pkg::*;
    localparam int N = NUM_SRC;
    localparam int TRIG_FACTOR = trig_factor(CHANNEL);

    logic         tx_hit;
    logic [N-1:0] set_vec;
    logic [N-1:0] clr_vec;

    uirq_tx_thresh #(.CHANNEL(CHANNEL), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_thresh (
        .fifo_en (fifo_en),
        .code    (tx_trig_code),
        .count   (tx_count),
        .tx_hit  (tx_hit)
    );

    // Set and clear vectors for the source register.
    always_comb begin
        set_vec = src_set;
        set_vec[SRC_TX] = src_set[SRC_TX] | tx_write_done | tx_hit;
        clr_vec = (pend_wr ? wr_data : '0) | (srcp_wr ? wr_data : '0);
    end

    uirq_src_reg #(.N(N)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .q       (srcp_q)
    );

    uirq_pend_gen #(.N(N)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_wr (mask_wr),
        .wr_data (wr_data),
        .srcp    (srcp_q),
        .mask_q  (mask_q),
        .pend    (pend),
        .irq     (irq)
    );

    // R2: no pending bit without its source, none through the mask
    assert_pend_view_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & mask_q) == '0) && ((pend & ~srcp_q) == '0));

    // R3: an unmasked source drives the line
    assert_irq_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((srcp_q & ~mask_q) != '0) |-> irq);

    // R3: a low line means nothing is pending
    assert_irq_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (pend == '0));

    // R7: a threshold match sets the transmit source
    assert_thresh_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && (int'(tx_count) <= int'(tx_trig_code) * TRIG_FACTOR)) |=> srcp_q[SRC_TX]);

    // R9: a completed transmit write sets the transmit source
    assert_txdone_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_write_done |=> srcp_q[SRC_TX]);
endmodule

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] src_set;
    logic       tx_write_done;
    logic       fifo_en;
    logic [2:0] tx_trig_code;
    logic [7:0] tx_count;
    logic       pend_wr, srcp_wr, mask_wr;
    logic [3:0] wr_data;
    logic [3:0] srcp_q, mask_q, pend;
    logic       irq;
    logic [3:0] s1, s2, s3, m1, m2, m3, p1, p2, p3;
    logic       i1, i2, i3;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    uart_irq_ctrl #(.CHANNEL(0)) u0 (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .tx_write_done(tx_write_done),
        .fifo_en(fifo_en), .tx_trig_code(tx_trig_code), .tx_count(tx_count),
        .pend_wr(pend_wr), .srcp_wr(srcp_wr), .mask_wr(mask_wr), .wr_data(wr_data),
        .srcp_q(srcp_q), .mask_q(mask_q), .pend(pend), .irq(irq));
    uart_irq_ctrl #(.CHANNEL(1)) u1 (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .tx_write_done(tx_write_done),
        .fifo_en(fifo_en), .tx_trig_code(tx_trig_code), .tx_count(tx_count),
        .pend_wr(pend_wr), .srcp_wr(srcp_wr), .mask_wr(mask_wr), .wr_data(wr_data),
        .srcp_q(s1), .mask_q(m1), .pend(p1), .irq(i1));
    uart_irq_ctrl #(.CHANNEL(2)) u2 (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .tx_write_done(tx_write_done),
        .fifo_en(fifo_en), .tx_trig_code(tx_trig_code), .tx_count(tx_count),
        .pend_wr(pend_wr), .srcp_wr(srcp_wr), .mask_wr(mask_wr), .wr_data(wr_data),
        .srcp_q(s2), .mask_q(m2), .pend(p2), .irq(i2));
    uart_irq_ctrl #(.CHANNEL(7)) u3 (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .tx_write_done(tx_write_done),
        .fifo_en(fifo_en), .tx_trig_code(tx_trig_code), .tx_count(tx_count),
        .pend_wr(pend_wr), .srcp_wr(srcp_wr), .mask_wr(mask_wr), .wr_data(wr_data),
        .srcp_q(s3), .mask_q(m3), .pend(p3), .irq(i3));

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // One clock edge, then settle 1 ns after it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_set(input logic [3:0] v);
        src_set = v; step(); src_set = '0;
    endtask

    task automatic wr(input logic p, input logic s, input logic m, input logic [3:0] d);
        pend_wr = p; srcp_wr = s; mask_wr = m; wr_data = d;
        step();
        pend_wr = 0; srcp_wr = 0; mask_wr = 0; wr_data = '0;
    endtask

    function automatic int factor(input int ch);
        case (ch)
            0: return 32;
            1, 4: return 8;
            2, 3: return 2;
            default: return 0;
        endcase
    endfunction

    task automatic t_reset();
        rst_n = 0; src_set = '0; tx_write_done = 0; fifo_en = 0; tx_trig_code = '0;
        tx_count = 8'd255; pend_wr = 0; srcp_wr = 0; mask_wr = 0; wr_data = '0;
        repeat (3) step();
        chk("R11 srcp after reset", srcp_q, 0);
        chk("R11 mask after reset", mask_q, 0);
        chk("R11 irq after reset", irq, 0);
        rst_n = 1; step();
    endtask

    task automatic t_set_bits();
        logic [3:0] exp = '0;
        for (int i = 0; i < 4; i++) begin
            pulse_set(4'(1 << i));
            exp[i] = 1'b1;
            chk("R1 source bit set", srcp_q, exp);
        end
        step();
        chk("R1 source bits sticky", srcp_q, 4'hF);
        wr(0, 1, 0, 4'hF);
        chk("R5 source write clears all", srcp_q, 0);
    endtask

    task automatic t_mask();
        pulse_set(4'b1001);
        wr(0, 0, 1, 4'b0001);
        chk("R6 mask loaded", mask_q, 4'b0001);
        chk("R6 source unchanged by mask write", srcp_q, 4'b1001);
        chk("R2 pending masked", pend, 4'b1000);
        chk("R3 irq with pending", irq, 1);
        mask_wr = 1; wr_data = 4'b1001; step();
        chk("R2 pending fully masked", pend, 0);
        chk("R3 irq low when all masked", irq, 0);
        wr_data = 4'b0000; step();
        mask_wr = 0;
        chk("R2 pending after unmask", pend, 4'b1001);
    endtask

    task automatic t_pend_clear();
        wr(1, 0, 0, 4'b0001);
        chk("R4 pending write clears source", srcp_q, 4'b1000);
        chk("R4 pending bit dropped", pend, 4'b1000);
        wr(1, 0, 0, 4'b1000);
        chk("R4 all cleared", srcp_q, 0);
        chk("R3 irq low after clear", irq, 0);
    endtask

    task automatic t_src_partial();
        pulse_set(4'hF);
        wr(0, 1, 0, 4'b0110);
        chk("R5 partial clear keeps others", srcp_q, 4'b1001);
        wr(0, 1, 0, 4'hF);
    endtask

    task automatic t_txdone();
        tx_write_done = 1; step(); tx_write_done = 0;
        chk("R9 transmit write sets tx bit", srcp_q, 4'b0100);
        wr(0, 1, 0, 4'hF);
    endtask

    task automatic t_thresh();
        fifo_en = 1; tx_trig_code = 3'd2; tx_count = 8'd64; step();
        chk("R7 count at level sets tx", srcp_q[2], 1);
        wr(0, 1, 0, 4'b0100);
        chk("R10 threshold beats clear", srcp_q[2], 1);
        tx_count = 8'd65;
        wr(0, 1, 0, 4'b0100);
        step();
        chk("R7 count above level no set", srcp_q[2], 0);
        fifo_en = 0; tx_count = 8'd0;
        step(); step();
        chk("R7 disabled fifo ignores threshold", srcp_q[2], 0);
    endtask

    task automatic t_channels();
        int counts [5] = '{0, 6, 7, 25, 97};
        fifo_en = 1; tx_trig_code = 3'd3;
        foreach (counts[k]) begin
            tx_count = 8'd255;
            wr(0, 1, 0, 4'hF);
            tx_count = 8'(counts[k]);
            step();
            chk("R8 ch0 level", srcp_q[2], int'(counts[k] <= 3 * factor(0)));
            chk("R8 ch1 level", s1[2], int'(counts[k] <= 3 * factor(1)));
            chk("R8 ch2 level", s2[2], int'(counts[k] <= 3 * factor(2)));
            chk("R8 ch7 level", s3[2], int'(counts[k] <= 3 * factor(7)));
        end
        fifo_en = 0; tx_count = 8'd255;
        wr(0, 1, 0, 4'hF);
    endtask

    task automatic t_set_vs_clear();
        src_set = 4'b0001; srcp_wr = 1; wr_data = 4'b0011; step();
        src_set = '0; srcp_wr = 0; wr_data = '0;
        chk("R10 set wins over clear", srcp_q, 4'b0001);
        wr(0, 1, 0, 4'hF);
    endtask

    initial begin
        t_reset();
        t_set_bits();
        t_mask();
        t_pend_clear();
        t_src_partial();
        t_txdone();
        t_thresh();
        t_channels();
        t_set_vs_clear();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule